// File: doc/BRIEF.md
# Latency-Table Issue Interlock

This block sits at the issue stage of an in-order pipeline that has a single-cycle integer unit, a load path and a pipelined floating-point adder. Every cycle it looks at the instruction waiting to issue. It holds that instruction back when one of its sources is produced by a recently issued instruction whose result is not yet usable. When nothing blocks the instruction, it raises an issue strobe.

For every issued instruction that has a non-zero result latency, the block keeps a small table entry. The entry holds the register file, the register number, the producer class and a countdown. The number of cycles that must pass depends on both sides of the dependence: the class of the producer and the way the consumer uses the value. The block looks this up in a producer-by-consumer matrix. A store that only forwards a floating-point value as its data therefore waits less than a floating-point add that computes with it. The countdowns decrement every cycle, including bubble and stall cycles. A stalled instruction keeps everything behind it waiting and is never entered into the table.

Instruction class encoding on `in_cls`: 0 = integer op, 1 = load double, 2 = FP ALU op, 3 = store double, 4 = branch. The source files depend on the class:
- An integer op reads two integer sources.
- A load reads its address (source A) from the integer file.
- An FP ALU op reads two FP sources.
- A store reads its address (A) from the integer file and its data (B) from the FP file.
- A branch reads integer source A.

Integer ops write the integer file. Loads and FP ALU ops write the FP file. Stores and branches write nothing.

Top module: `iil_issue_ctrl`

## Requirements
- R1: An FP ALU op (class 2) reading an FP register written by the FP ALU op issued just before it stalls exactly 3 cycles. No single instruction ever stalls more than 3 consecutive cycles.
- R2: A store double (class 3) whose data source B is an FP ALU result issued just before stalls exactly 2 cycles.
- R3: An FP ALU op reading the result of a load double (class 1) issued just before stalls exactly 1 cycle.
- R4: A store whose data is the result of the load issued just before stalls 0 cycles. An integer op (class 0) reading the result of the integer op just before stalls 0 cycles.
- R5: Integer and FP registers with the same number never interact. Classes 0, 1 and 4 read only integer registers and therefore never stall.
- R6: Every cycle after a producer issues counts toward its latency, whether it is an independent instruction, a bubble (`in_valid` low) or a stall. The stall length is max(0, latency − elapsed intervening cycles).
- R7: `issue_o` = `in_valid` and not `stall_o`. Both are low when `in_valid` is low.
- R8: A stalled instruction is held and is not recorded as a producer. Its own result latency counts from the cycle it actually issues.
- R9: When two in-flight producers write the same register, only the newest one governs the stall.
- R10: A source whose valid bit is low causes no stall. Stores and branches record no destination, whatever `in_dst` holds.
- R11: After reset, no producer is pending and the first instruction issues without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is waiting to issue |
| in_cls | input | 3 | Class of the waiting instruction (encoding above) |
| in_dst | input | REG_W | Destination register number |
| in_src_a_vld | input | 1 | Source A is used |
| in_src_a | input | REG_W | Source A register number |
| in_src_b_vld | input | 1 | Source B is used |
| in_src_b | input | REG_W | Source B register number |
| stall_o | output | 1 | Waiting instruction must be held this cycle |
| issue_o | output | 1 | Waiting instruction issues this cycle |

## Verification
The dependent instruction is tried directly behind each producer class, for each kind of consumer. This separates the four matrix entries from one another and from a single fixed latency. The same producers are then followed by one or two independent instructions or bubbles. Those patterns show whether countdowns run during filler and stall cycles. Register numbers are shared across the integer and FP files to expose any namespace mixing. Chained FP dependences and reused destination registers separate "counted from real issue" and "newest writer wins" from their faulty alternatives.

// File: rtl/iil_pkg.sv
package iil_pkg;

    localparam int REG_W = 5;
    localparam int CNT_W = 2;

    typedef enum logic [2:0] {
        CLS_INT = 3'd0,
        CLS_LDD = 3'd1,
        CLS_FPA = 3'd2,
        CLS_STD = 3'd3,
        CLS_BR  = 3'd4
    } iclass_e;

    typedef struct packed {
        logic             fp;
        logic [REG_W-1:0] rn;
        iclass_e          cls;
        logic [CNT_W-1:0] cnt;
    } ent_t;

    // Countdown loaded when a producer of this class issues.
    function automatic logic [CNT_W-1:0] max_lat(iclass_e p);
        case (p)
            CLS_FPA: max_lat = CNT_W'(3);
            CLS_LDD: max_lat = CNT_W'(1);
            default: max_lat = '0;
        endcase
    endfunction

    // Intervening cycles needed between producer p and consumer c.
    function automatic logic [CNT_W-1:0] need_lat(iclass_e p, iclass_e c);
        case (p)
            CLS_FPA: need_lat = (c == CLS_STD) ? CNT_W'(2) : CNT_W'(3);
            CLS_LDD: need_lat = (c == CLS_STD) ? CNT_W'(0) : CNT_W'(1);
            default: need_lat = '0;
        endcase
    endfunction

    // Countdown value above which the consumer must wait.
    function automatic logic [CNT_W-1:0] wait_thr(iclass_e p, iclass_e c);
        wait_thr = max_lat(p) - need_lat(p, c);
    endfunction

    function automatic logic src_a_fp(iclass_e c);
        src_a_fp = (c == CLS_FPA);
    endfunction

    function automatic logic src_b_fp(iclass_e c);
        src_b_fp = (c == CLS_FPA) || (c == CLS_STD);
    endfunction

    function automatic logic dst_fp(iclass_e c);
        dst_fp = (c == CLS_FPA) || (c == CLS_LDD);
    endfunction

endpackage

// File: rtl/iil_track.sv
module iil_track
    import iil_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_i,
    input  logic                  alloc_fp_i,
    input  logic [REG_W-1:0]      alloc_rn_i,
    input  iclass_e               alloc_cls_i,
    output ent_t [DEPTH-1:0]      ents_o
);

    typedef struct packed {
        ent_t [DEPTH-1:0] e;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic    placed;

    always_comb begin
        st_d   = st_q;
        placed = 1'b0;
        // age every entry; drop an older writer of the same register
        for (int i = 0; i < DEPTH; i++) begin
            if (st_d.e[i].cnt != '0)
                st_d.e[i].cnt = st_d.e[i].cnt - 1'b1;
            if (alloc_i && st_d.e[i].fp == alloc_fp_i && st_d.e[i].rn == alloc_rn_i)
                st_d.e[i].cnt = '0;
        end
        // place the new producer in the first free slot
        for (int i = 0; i < DEPTH; i++) begin
            if (alloc_i && !placed && st_d.e[i].cnt == '0) begin
                st_d.e[i].fp  = alloc_fp_i;
                st_d.e[i].rn  = alloc_rn_i;
                st_d.e[i].cls = alloc_cls_i;
                st_d.e[i].cnt = max_lat(alloc_cls_i);
                placed        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ents_o = st_q.e;

endmodule

// File: rtl/iil_hazard.sv
module iil_hazard
    import iil_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  ent_t [DEPTH-1:0]  ents_i,
    input  iclass_e           cls_i,
    input  logic              a_vld_i,
    input  logic [REG_W-1:0]  a_i,
    input  logic              b_vld_i,
    input  logic [REG_W-1:0]  b_i,
    output logic              hazard_o
);

    logic [DEPTH-1:0] hit_a, hit_b;
    logic             a_fp, b_fp;

    assign a_fp = src_a_fp(cls_i);
    assign b_fp = src_b_fp(cls_i);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic busy;
        assign busy     = ents_i[g].cnt > wait_thr(ents_i[g].cls, cls_i);
        assign hit_a[g] = busy && a_vld_i && ents_i[g].fp == a_fp && ents_i[g].rn == a_i;
        assign hit_b[g] = busy && b_vld_i && ents_i[g].fp == b_fp && ents_i[g].rn == b_i;
    end

    assign hazard_o = (|hit_a) || (|hit_b);

endmodule

// File: rtl/iil_issue_ctrl.sv
module iil_issue_ctrl
    import iil_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_cls,
    input  logic [REG_W-1:0] in_dst,
    input  logic             in_src_a_vld,
    input  logic [REG_W-1:0] in_src_a,
    input  logic             in_src_b_vld,
    input  logic [REG_W-1:0] in_src_b,
    output logic             stall_o,
    output logic             issue_o
);

    iclass_e          cls;
    ent_t [DEPTH-1:0] ents;
    logic             hazard;
    logic             alloc;

    assign cls = iclass_e'(in_cls);

    iil_hazard #(.DEPTH(DEPTH)) u_haz (
        .ents_i   (ents),
        .cls_i    (cls),
        .a_vld_i  (in_src_a_vld),
        .a_i      (in_src_a),
        .b_vld_i  (in_src_b_vld),
        .b_i      (in_src_b),
        .hazard_o (hazard)
    );

    assign stall_o = in_valid && hazard;
    assign issue_o = in_valid && !hazard;
    assign alloc   = issue_o && (max_lat(cls) != '0);

    iil_track #(.DEPTH(DEPTH)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (alloc),
        .alloc_fp_i  (dst_fp(cls)),
        .alloc_rn_i  (in_dst),
        .alloc_cls_i (cls),
        .ents_o      (ents)
    );

endmodule

// File: rtl/iil_issue_ctrl_chk.sv
module iil_issue_ctrl_chk
    import iil_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_cls,
    input logic [REG_W-1:0] in_dst,
    input logic             in_src_a_vld,
    input logic [REG_W-1:0] in_src_a,
    input logic             in_src_b_vld,
    input logic [REG_W-1:0] in_src_b,
    input logic             stall_o,
    input logic             issue_o
);

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_o && stall_o));

    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!stall_o && !issue_o));

    a_r5_int_reads_free: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_cls == 3'd0 || in_cls == 3'd1 || in_cls == 3'd4)) |-> issue_o);

    a_r1_fp_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cls == 3'd2 && in_src_a_vld && $past(issue_o)
         && $past(in_cls) == 3'd2 && in_src_a == $past(in_dst)) |-> stall_o);

    a_r2_fp_to_store: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cls == 3'd3 && in_src_b_vld && $past(issue_o)
         && $past(in_cls) == 3'd2 && in_src_b == $past(in_dst)) |-> stall_o);

    a_r3_load_use: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cls == 3'd2 && in_src_a_vld && $past(issue_o)
         && $past(in_cls) == 3'd1 && in_src_a == $past(in_dst)) |-> stall_o);

    a_r1_stall_run_max: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall_o && $past(stall_o) && $past(stall_o, 2) && $past(stall_o, 3)));

endmodule

bind iil_issue_ctrl iil_issue_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_cls       (in_cls),
    .in_dst       (in_dst),
    .in_src_a_vld (in_src_a_vld),
    .in_src_a     (in_src_a),
    .in_src_b_vld (in_src_b_vld),
    .in_src_b     (in_src_b),
    .stall_o      (stall_o),
    .issue_o      (issue_o)
);

// File: tb/iil_issue_ctrl_tb.sv
module iil_issue_ctrl_tb;

    localparam int C_INT = 0, C_LDD = 1, C_FPA = 2, C_STD = 3, C_BR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_cls = '0;
    logic [4:0] in_dst = '0;
    logic       in_src_a_vld = 1'b0;
    logic [4:0] in_src_a = '0;
    logic       in_src_b_vld = 1'b0;
    logic [4:0] in_src_b = '0;
    logic       stall_o, issue_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int lw_cyc [2][32];
    int lw_cls [2][32];
    bit finished = 0;

    always #4 clk = ~clk;

    iil_issue_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .in_dst(in_dst), .in_src_a_vld(in_src_a_vld), .in_src_a(in_src_a),
        .in_src_b_vld(in_src_b_vld), .in_src_b(in_src_b),
        .stall_o(stall_o), .issue_o(issue_o)
    );

    function automatic int need(int p, int c);
        if (p == C_FPA) return (c == C_STD) ? 2 : 3;
        if (p == C_LDD) return (c == C_STD) ? 0 : 1;
        return 0;
    endfunction

    function automatic bit src_stall(int f, int r, int c);
        return (cyc - lw_cyc[f][r]) <= need(lw_cls[f][r], c);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic next_edge();
        @(posedge clk);
        cyc++;
        #1;
    endtask

    task automatic bubble();
        in_valid = 1'b0;
        #1;
        chk(!stall_o && !issue_o, "R7 idle", {30'd0, stall_o, issue_o}, 0);
        next_edge();
    endtask

    task automatic run(input int c, input int dst, input bit av, input int a,
                       input bit bv, input int b, output int ns);
        bit exp_st;
        ns = 0;
        in_valid = 1'b1; in_cls = 3'(c); in_dst = 5'(dst);
        in_src_a_vld = av; in_src_a = 5'(a);
        in_src_b_vld = bv; in_src_b = 5'(b);
        while (1) begin
            #1;
            exp_st = (av && src_stall((c == C_FPA) ? 1 : 0, a, c)) ||
                     (bv && src_stall((c == C_FPA || c == C_STD) ? 1 : 0, b, c));
            chk(stall_o == exp_st, "R7 stall per cycle", int'(stall_o), int'(exp_st));
            chk(issue_o == !exp_st, "R7 issue per cycle", int'(issue_o), int'(!exp_st));
            if (!exp_st || ns > 8) break;
            ns++;
            next_edge();
        end
        if (c == C_INT) begin lw_cyc[0][dst] = cyc; lw_cls[0][dst] = c; end
        if (c == C_LDD || c == C_FPA) begin lw_cyc[1][dst] = cyc; lw_cls[1][dst] = c; end
        next_edge();
        in_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int ns;
        for (int f = 0; f < 2; f++)
            for (int r = 0; r < 32; r++) begin
                lw_cyc[f][r] = -1000;
                lw_cls[f][r] = C_INT;
            end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        next_edge();
        cyc = 0;

        // R11: reset state
        #1;
        chk(!stall_o && !issue_o, "R11 reset idle", int'(stall_o), 0);
        run(C_FPA, 4, 1, 0, 1, 2, ns);
        chk(ns == 0, "R11 first issue", ns, 0);

        // R1: FP ALU -> FP ALU
        run(C_FPA, 6, 1, 4, 0, 0, ns);
        chk(ns == 3, "R1 fpa->fpa", ns, 3);

        // R2: FP ALU -> store data
        run(C_FPA, 8, 1, 1, 1, 3, ns);
        run(C_STD, 0, 1, 1, 1, 8, ns);
        chk(ns == 2, "R2 fpa->store", ns, 2);

        // R3: load -> FP ALU
        run(C_LDD, 10, 1, 1, 0, 0, ns);
        run(C_FPA, 12, 1, 10, 1, 3, ns);
        chk(ns == 1, "R3 load->fpa", ns, 1);

        // R4: load -> store data, int -> int
        run(C_LDD, 14, 1, 2, 0, 0, ns);
        run(C_STD, 0, 1, 2, 1, 14, ns);
        chk(ns == 0, "R4 load->store", ns, 0);
        run(C_INT, 3, 1, 1, 1, 2, ns);
        run(C_INT, 9, 1, 3, 1, 3, ns);
        chk(ns == 0, "R4 int->int", ns, 0);

        // R5: namespaces
        run(C_FPA, 5, 1, 0, 0, 0, ns);
        run(C_STD, 0, 1, 5, 1, 0, ns);
        chk(ns == 0, "R5 int r5 vs fp f5", ns, 0);
        run(C_FPA, 7, 1, 0, 0, 0, ns);
        run(C_BR, 0, 1, 7, 0, 0, ns);
        chk(ns == 0, "R5 branch reads int r7", ns, 0);

        // R6: intervening instructions and bubbles count
        run(C_FPA, 16, 1, 0, 0, 0, ns);
        run(C_INT, 11, 1, 1, 0, 0, ns);
        run(C_INT, 13, 1, 1, 0, 0, ns);
        run(C_FPA, 17, 1, 16, 0, 0, ns);
        chk(ns == 1, "R6 two fillers", ns, 1);
        run(C_FPA, 24, 1, 0, 0, 0, ns);
        bubble();
        run(C_FPA, 25, 0, 0, 1, 24, ns);
        chk(ns == 2, "R6 one bubble", ns, 2);
        run(C_FPA, 26, 1, 0, 0, 0, ns);
        bubble(); bubble(); bubble();
        run(C_STD, 0, 1, 1, 1, 26, ns);
        chk(ns == 0, "R6 three bubbles", ns, 0);

        // R8: latency counts from real issue
        run(C_FPA, 18, 1, 0, 0, 0, ns);
        run(C_FPA, 19, 1, 18, 0, 0, ns);
        chk(ns == 3, "R8 middle of chain", ns, 3);
        run(C_FPA, 20, 1, 19, 0, 0, ns);
        chk(ns == 3, "R8 end of chain", ns, 3);

        // R9: newest writer governs
        run(C_FPA, 21, 1, 0, 0, 0, ns);
        run(C_LDD, 21, 1, 1, 0, 0, ns);
        run(C_FPA, 22, 1, 21, 0, 0, ns);
        chk(ns == 1, "R9 newest writer", ns, 1);

        // R10: invalid sources and non-writers
        run(C_FPA, 23, 1, 0, 0, 0, ns);
        run(C_FPA, 27, 0, 23, 1, 0, ns);
        chk(ns == 0, "R10 invalid source", ns, 0);
        run(C_STD, 28, 1, 1, 1, 0, ns);
        run(C_FPA, 29, 1, 28, 0, 0, ns);
        chk(ns == 0, "R10 store has no dest", ns, 0);
        run(C_BR, 30, 1, 1, 0, 0, ns);
        run(C_FPA, 31, 1, 30, 0, 0, ns);
        chk(ns == 0, "R10 branch has no dest", ns, 0);

        bubble();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule